// File: doc/BRIEF.md
# SPI Burst Shift Engine

This block is the serial core of a byte-wide SPI master. A register file hands it a control word and two byte counts. A transmit FIFO feeds it bytes, and a receive FIFO takes the bytes it captures. An external divider supplies a one-cycle enable tick, and each tick is one half period of the serial clock. Writing the control word with its top bit set launches one burst. The engine then drives the serial clock, the data line and one of four chip-select lines. It pulses `done` once every byte of the burst has been shifted.

Two counts set the shape of a burst. The burst count is the total number of bytes clocked. The transmit count is how many of those bytes are taken from the transmit FIFO; once it is used up, the engine sends zero bytes and pops nothing more. If the transmit FIFO runs dry before the transmit count is reached, the serial clock pauses until data arrives. A discard option drops the received bytes, so write-only traffic does not fill the receive FIFO. Chip select can follow the transfer, or it can be held at a level that software sets.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset the control readback is zero, `sclk` and `done` are low, no FIFO handshake is asserted, and all four `cs_lines` are high.
- R2: Control bit 1 sets the idle level of `sclk`. Control bit 0 selects the phase: when clear, the receiver samples on the first edge of each clock period; when set, it samples on the second. Each byte takes exactly 16 `sclk` edges, and each edge occurs only in a cycle where `sck_tick` is high.
- R3: Control bit 12 set shifts each byte least significant bit first on both `mosi` and `miso`. When it is clear, the most significant bit goes first.
- R4: Control bits 5:4 pick the chip-select line. Control bit 2 sets the active level (0 = active low). Lines that are not selected stay at the inactive level.
- R5: In automatic mode the selected line becomes active one tick before the first `sclk` edge, so the first edge falls on the second tick. The line returns to inactive on the tick after the last edge.
- R6: When control bit 6 is set, the selected line carries control bit 7 directly, whether the engine is idle or busy.
- R7: When control bit 8 is set, no received byte is pushed into the receive FIFO.
- R8: A burst clocks exactly `burst_cnt` bytes. The first `tx_cnt` of them are popped from the transmit FIFO, and any bytes after those are sent as 0x00 with no pop.
- R9: If a byte is needed from the transmit FIFO while `tx_empty` is high, `sclk` holds still and no pop is made until data arrives.
- R10: Writing the control word with bit 31 set while idle starts a burst. Readback bit 31 is 1 while the burst runs and clears itself at the end. Any control write made during a burst is ignored.
- R11: `done` pulses for one cycle, in the same cycle that the engine returns to idle. With a burst count of 0, `done` pulses in the cycle after the start write and no chip-select line moves.
- R12: Received bytes are pushed in arrival order. The push of one byte falls in the same cycle as the pop that loads the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_tick | input | 1 | Half-period enable from the clock divider |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word written |
| ctrl_rdata | output | 32 | Control word readback, bit 31 = burst active |
| burst_cnt | input | 24 | Total bytes in the burst |
| tx_cnt | input | 24 | Bytes taken from the transmit FIFO |
| tx_data | input | 8 | Head of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Pop the transmit FIFO |
| rx_wdata | output | 8 | Byte pushed to the receive FIFO |
| rx_push | output | 1 | Push to the receive FIFO |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_lines | output | 4 | Chip-select lines |
| done | output | 1 | Burst-complete pulse |

## Verification
Two actions can land in the same cycle. Finishing a byte registers its receive push, and in that same cycle the load state pops the next transmit byte. A three-byte burst with a full transmit FIFO and `miso` looped back to `mosi` makes this happen twice. The bench counts the cycles in which `tx_pop` and `rx_push` are both high and expects 2. It also requires that the received bytes match the sent bytes in order, which shows that neither action corrupted the other.

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_tick,
  input  logic             ctrl_we,
  input  logic [31:0]      ctrl_wdata,
  output logic [31:0]      ctrl_rdata,
  input  logic [CNT_W-1:0] burst_cnt,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [7:0]       tx_data,
  input  logic             tx_empty,
  output logic             tx_pop,
  output logic [7:0]       rx_wdata,
  output logic             rx_push,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic [3:0]       cs_lines,
  output logic             done
);
  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOAD, S_SHIFT, S_TRAIL} st_t;
  st_t st;

  logic [30:0]      ctrl_q;
  logic [CNT_W-1:0] left, txleft;
  logic [7:0]       tx_sr, rx_sr, rx_nxt, byte_in;
  logic [3:0]       ecnt;
  logic             sclk_q, mosi_q, done_q, push_q;
  logic [7:0]       rxw_q;

  wire cpha = ctrl_q[0], cpol = ctrl_q[1], cspol = ctrl_q[2];
  wire [1:0] csidx = ctrl_q[5:4];
  wire man = ctrl_q[6], lvl = ctrl_q[7], discard = ctrl_q[8], lsb = ctrl_q[12];

  wire busy   = (st != S_IDLE);
  wire start  = ctrl_we && !busy && ctrl_wdata[31];
  wire need_tx = (txleft != '0);
  wire load_ok = !need_tx || !tx_empty;
  wire lead   = ~ecnt[0];
  wire sample = lead ^ cpha;
  wire drive  = !sample && (ecnt != 4'd15);

  assign byte_in    = need_tx ? tx_data : 8'h00;
  assign tx_pop     = (st == S_LOAD) && need_tx && !tx_empty;
  assign ctrl_rdata = {busy, ctrl_q};
  assign sclk       = busy ? sclk_q : cpol;
  assign mosi       = mosi_q;
  assign done       = done_q;
  assign rx_push    = push_q;
  assign rx_wdata   = rxw_q;

  function automatic logic obit(input logic [7:0] d, input logic l);
    return l ? d[0] : d[7];
  endfunction

  function automatic logic [7:0] sh(input logic [7:0] d, input logic l);
    return l ? {1'b0, d[7:1]} : {d[6:0], 1'b0};
  endfunction

  assign rx_nxt = !sample ? rx_sr : (lsb ? {miso, rx_sr[7:1]} : {rx_sr[6:0], miso});

  wire sel_level = man ? lvl : (busy ? cspol : ~cspol);
  for (genvar i = 0; i < 4; i++) begin : g_cs
    assign cs_lines[i] = (csidx == i[1:0]) ? sel_level : ~cspol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ctrl_q <= '0;
      left   <= '0;
      txleft <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      ecnt   <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      push_q <= 1'b0;
      rxw_q  <= '0;
    end else begin
      done_q <= 1'b0;
      push_q <= 1'b0;
      if (ctrl_we && !busy) ctrl_q <= ctrl_wdata[30:0];
      case (st)
        S_IDLE: if (start) begin
          if (burst_cnt == '0) done_q <= 1'b1;
          else begin
            st     <= S_LEAD;
            left   <= burst_cnt;
            txleft <= tx_cnt;
            sclk_q <= ctrl_wdata[1];
          end
        end
        S_LEAD: if (sck_tick) st <= S_LOAD;
        S_LOAD: if (load_ok) begin
          if (cpha) tx_sr <= byte_in;
          else begin
            mosi_q <= obit(byte_in, lsb);
            tx_sr  <= sh(byte_in, lsb);
          end
          if (need_tx) txleft <= txleft - 1'b1;
          ecnt <= '0;
          st   <= S_SHIFT;
        end
        S_SHIFT: if (sck_tick) begin
          sclk_q <= ~sclk_q;
          ecnt   <= ecnt + 1'b1;
          rx_sr  <= rx_nxt;
          if (drive) begin
            mosi_q <= obit(tx_sr, lsb);
            tx_sr  <= sh(tx_sr, lsb);
          end
          if (ecnt == 4'd15) begin
            push_q <= !discard;
            rxw_q  <= rx_nxt;
            left   <= left - 1'b1;
            st     <= (left == 1) ? S_TRAIL : S_LOAD;
          end
        end
        S_TRAIL: if (sck_tick) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
          mosi_q <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_engine_chk.sv
module spi_burst_engine_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck_tick,
  input logic             ctrl_we,
  input logic [31:0]      ctrl_wdata,
  input logic [31:0]      ctrl_rdata,
  input logic [CNT_W-1:0] burst_cnt,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [7:0]       tx_data,
  input logic             tx_empty,
  input logic             tx_pop,
  input logic [7:0]       rx_wdata,
  input logic             rx_push,
  input logic             sclk,
  input logic             mosi,
  input logic             miso,
  input logic [3:0]       cs_lines,
  input logic             done
);
  // R9
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  // R2
  sclk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[31] && $past(ctrl_rdata[31]) && (sclk != $past(sclk))) |-> $past(sck_tick));

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[31] |-> (sclk == ctrl_rdata[1]));

  // R4
  one_cs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_lines ^ {4{~ctrl_rdata[2]}}) <= 1);

  // R7
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !ctrl_rdata[8]);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ctrl_rdata[31]);
endmodule

bind spi_burst_engine spi_burst_engine_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/spi_burst_engine_tb.sv
module spi_burst_engine_tb;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic sck_tick = 0, ctrl_we = 0;
  logic [31:0] ctrl_wdata = 0, ctrl_rdata;
  logic [23:0] burst_cnt = 0, tx_cnt = 0;
  logic [7:0] tx_data, rx_wdata;
  logic tx_empty, tx_pop, rx_push, sclk, mosi, miso, done;
  logic [3:0] cs_lines;
  assign miso = mosi;

  spi_burst_engine u_dut (.*);

  int pass_n = 0, total_n = 0;
  logic [7:0] txq [0:15];
  int txw = 0, txr = 0;
  assign tx_empty = (txr == txw);
  assign tx_data  = txq[txr % 16];

  logic [7:0] rxq [0:63];
  logic [7:0] monq [0:63];
  int rxn = 0, popn = 0, coll = 0, donen = 0, tickn = 0, tdiv = 0;
  int monn = 0, mbits = 0, edgen = 0;
  int cs_on_tick = 0, cs_off_tick = 0, first_edge_tick = 0, last_edge_tick = 0;
  logic [7:0] msr = 0;
  logic [3:0] cs_edge_snap = 0;
  logic act_p = 0, sclk_p = 0, busy_p = 0, need_first = 0;

  always @(posedge clk) begin
    if (tx_pop) begin txr <= txr + 1; popn <= popn + 1; end
    if (rx_push) begin rxq[rxn % 64] <= rx_wdata; rxn <= rxn + 1; end
    if (tx_pop && rx_push) coll <= coll + 1;
    if (done) donen <= donen + 1;
    if (sck_tick) tickn <= tickn + 1;
  end

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    sck_tick = (tdiv == 0);
  end

  always @(negedge clk) begin
    logic act, busy;
    busy = ctrl_rdata[31];
    act = (cs_lines[ctrl_rdata[5:4]] == ctrl_rdata[2]);
    if (act && !act_p) cs_on_tick = tickn;
    if (!act && act_p) cs_off_tick = tickn;
    act_p = act;
    if (busy && !busy_p) need_first = 1;
    if (rst_n && busy && busy_p && sclk != sclk_p) begin
      if (need_first) begin first_edge_tick = tickn; need_first = 0; end
      last_edge_tick = tickn;
      cs_edge_snap = cs_lines;
      edgen++;
      if ((sclk != ctrl_rdata[1]) == !ctrl_rdata[0]) begin
        msr = {msr[6:0], mosi};
        mbits++;
        if (mbits == 8) begin monq[monn % 64] = msr; monn++; mbits = 0; end
      end
    end
    sclk_p = sclk;
    busy_p = busy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total_n++;
    if (ok) pass_n++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  task automatic push_tx(input logic [7:0] d);
    txq[txw % 16] = d;
    txw++;
  endtask

  function automatic logic [7:0] rev(input logic [7:0] d);
    for (int i = 0; i < 8; i++) rev[i] = d[7-i];
  endfunction

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk);
    ctrl_wdata = v; ctrl_we = 1;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic wait_done(input int base);
    for (int i = 0; i < 5000 && donen <= base; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] c, input int nb, input int nt);
    int b;
    b = donen;
    burst_cnt = nb; tx_cnt = nt;
    wr_ctrl(c | 32'h8000_0000);
    wait_done(b);
  endtask

  task automatic t_reset();
    chk(ctrl_rdata == 0 && sclk == 0 && done == 0 && !tx_pop && !rx_push, "R1 idle outputs", ctrl_rdata, 0);
    chk(cs_lines == 4'hF, "R1 cs lines", cs_lines, 4'hF);
  endtask

  task automatic t_mode0();
    logic [7:0] d [3] = '{8'hA5, 8'h3C, 8'hF0};
    int m0, r0, p0, e0, c0;
    m0 = monn; r0 = rxn; p0 = popn; e0 = edgen; c0 = coll;
    foreach (d[i]) push_tx(d[i]);
    run(32'h0, 3, 3);
    for (int i = 0; i < 3; i++) begin
      chk(monq[(m0+i)%64] == d[i], "R2 mode0 mosi byte", monq[(m0+i)%64], d[i]);
      chk(rxq[(r0+i)%64] == d[i], "R12 rx order", rxq[(r0+i)%64], d[i]);
    end
    chk(edgen - e0 == 48, "R2 edges per byte", edgen - e0, 48);
    chk(popn - p0 == 3, "R8 pops", popn - p0, 3);
    chk(coll - c0 == 2, "R12 push with pop", coll - c0, 2);
    chk(first_edge_tick - cs_on_tick == 2, "R5 lead ticks", first_edge_tick - cs_on_tick, 2);
    chk(cs_off_tick - last_edge_tick == 1, "R5 trail ticks", cs_off_tick - last_edge_tick, 1);
    chk(cs_edge_snap == 4'b1110, "R4 cs index 0", cs_edge_snap, 4'b1110);
    chk(ctrl_rdata[31] == 0 && cs_lines == 4'hF, "R10 self clear", ctrl_rdata, 0);
  endtask

  task automatic t_mode3_lsb();
    int m0, r0;
    m0 = monn; r0 = rxn;
    push_tx(8'h81); push_tx(8'h96);
    run(32'h0000_1027, 2, 2);
    chk(monq[m0%64] == rev(8'h81), "R3 lsb first b0", monq[m0%64], rev(8'h81));
    chk(monq[(m0+1)%64] == rev(8'h96), "R3 lsb first b1", monq[(m0+1)%64], rev(8'h96));
    chk(rxq[(r0+1)%64] == 8'h96, "R3 lsb rx", rxq[(r0+1)%64], 8'h96);
    chk(cs_edge_snap == 4'b0100, "R4 idx2 active high", cs_edge_snap, 4'b0100);
    chk(sclk == 1 && cs_lines == 4'b0000, "R2 idle cpol1", {cs_lines, sclk}, 1);
  endtask

  task automatic t_dummy();
    int m0, p0, r0;
    m0 = monn; p0 = popn; r0 = rxn;
    push_tx(8'h77);
    run(32'h0, 3, 1);
    chk(monq[m0%64] == 8'h77 && monq[(m0+1)%64] == 0 && monq[(m0+2)%64] == 0, "R8 zero fill",
        {monq[m0%64], monq[(m0+1)%64], monq[(m0+2)%64]}, 24'h770000);
    chk(popn - p0 == 1, "R8 single pop", popn - p0, 1);
    chk(rxn - r0 == 3, "R8 burst length", rxn - r0, 3);
  endtask

  task automatic t_discard();
    int r0, p0, m0;
    r0 = rxn; p0 = popn; m0 = monn;
    push_tx(8'h12); push_tx(8'h34);
    run(32'h0000_0100, 2, 2);
    chk(rxn == r0, "R7 no rx push", rxn - r0, 0);
    chk(popn - p0 == 2 && monq[(m0+1)%64] == 8'h34, "R7 tx still sent", popn - p0, 2);
  endtask

  task automatic t_manual();
    int m0;
    wr_ctrl(32'h0000_0050);
    @(negedge clk);
    chk(cs_lines == 4'b1101, "R6 manual low idle", cs_lines, 4'b1101);
    wr_ctrl(32'h0000_00D0);
    @(negedge clk);
    chk(cs_lines == 4'b1111, "R6 manual high idle", cs_lines, 4'b1111);
    m0 = monn;
    push_tx(8'h5A);
    run(32'h0000_0050, 1, 1);
    chk(cs_edge_snap == 4'b1101 && cs_lines == 4'b1101, "R6 manual during burst", cs_edge_snap, 4'b1101);
    chk(monq[m0%64] == 8'h5A, "R6 manual data", monq[m0%64], 8'h5A);
  endtask

  task automatic t_stall();
    int e0, b, m0;
    logic s;
    e0 = edgen; b = donen; m0 = monn;
    push_tx(8'hC3);
    burst_cnt = 2; tx_cnt = 2;
    wr_ctrl(32'h8000_0000);
    repeat (100) @(negedge clk);
    s = sclk;
    repeat (30) @(negedge clk);
    chk(edgen - e0 == 16 && ctrl_rdata[31], "R9 stalled after one byte", edgen - e0, 16);
    chk(sclk == s && !tx_pop, "R9 clock held", sclk, s);
    push_tx(8'h3E);
    wait_done(b);
    chk(edgen - e0 == 32 && monq[(m0+1)%64] == 8'h3E, "R9 resumes", monq[(m0+1)%64], 8'h3E);
  endtask

  task automatic t_busy_write();
    int b, e0;
    b = donen; e0 = edgen;
    push_tx(8'h11); push_tx(8'h22);
    burst_cnt = 2; tx_cnt = 2;
    wr_ctrl(32'h8000_0000);
    repeat (20) @(negedge clk);
    wr_ctrl(32'h8000_0002);
    chk(ctrl_rdata[31] == 1 && ctrl_rdata[1] == 0, "R10 write while busy", ctrl_rdata, 32'h8000_0000);
    wait_done(b);
    repeat (40) @(negedge clk);
    chk(donen - b == 1 && edgen - e0 == 32, "R10 no restart", donen - b, 1);
  endtask

  task automatic t_zero();
    int on0;
    on0 = cs_on_tick;
    burst_cnt = 0; tx_cnt = 0;
    @(negedge clk);
    ctrl_wdata = 32'h8000_0000; ctrl_we = 1;
    @(negedge clk);
    ctrl_we = 0;
    chk(done == 1 && ctrl_rdata[31] == 0, "R11 zero burst done", done, 1);
    @(negedge clk);
    chk(done == 0, "R11 single cycle", done, 0);
    chk(cs_lines == 4'hF && cs_on_tick == on0, "R11 no cs activity", cs_lines, 4'hF);
  endtask

  bit finished = 0;
  initial begin
    #1_000_000;
    if (!finished) begin
      total_n++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", pass_n, total_n);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_mode0();
    t_mode3_lsb();
    t_dummy();
    t_discard();
    t_manual();
    t_stall();
    t_busy_write();
    t_zero();
    finished = 1;
    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end
endmodule